// File: doc/BRIEF.md
# Reconfigurable Spread-Spectrum Transmit Baseband

This block turns a serial user bit stream into direct-sequence spread chips for I and Q. Bits arrive over a ready/valid handshake, grouped into frames by a last flag. An optional rate-1/2 convolutional encoder sits in front of the symbol mapper. The mapper forms BPSK or QPSK symbols. Each symbol is then multiplied by a pseudo-noise chip code. The code is 16, 32, 64 or 128 chips long, which gives roughly 12 to 21 dB of processing gain. An unspread mode sends one chip per symbol.

A free-running divider sets the chip rate from the system clock. With the spreading factor, it sets the user bit rate. This covers the 8 to 64 kbps spread rates and the 1 Mbps unspread rate across a 1 to 16 MHz system clock. Settings are written into a shadow copy at any time. They reach the active configuration only while no frame is in flight, so a frame is always sent with one consistent configuration.

Top module: `dsss_tx`

## Requirements
- R1: After reset `data_ready_o` is 1 and `chip_stb_o` is 0.
- R2: Chip strobes occur only on divider ticks, and a tick occurs once every `cfg_div_i`+1 clocks. Within a frame with `cfg_div_i` >= 2 and input held valid, consecutive strobes are exactly `cfg_div_i`+1 cycles apart.
- R3: Each symbol emits exactly 16 << `cfg_sf_i` chips (code 0..3 gives 16, 32, 64, 128) in spread mode.
- R4: Chip value equals symbol bit XOR PN bit. The PN generator is a 7-bit register s seeded to 7'h7F at every symbol start. It outputs s[6] and then shifts to {s[5:0], s[6]^s[5]}.
- R5: A chip bit 0 is driven as +1 (2'b01) and a chip bit 1 as -1 (2'b11) on both `chip_i_o` and `chip_q_o`.
- R6: With `cfg_qpsk_i`=0, every chip has `chip_i_o` equal to `chip_q_o`.
- R7: QPSK without FEC pairs input bits: the first bit of a pair goes to I and the second to Q. If a frame ends on an unpaired bit, that bit goes to I and Q carries 0.
- R8: With FEC on, each encoder input b is combined with the six previous inputs into v = {b, prev1..prev6}, with b at bit 6. The encoder produces g0 = ^(v & 7'o171) and g1 = ^(v & 7'o133). In BPSK, g0 and g1 are sent as two successive symbols. In QPSK, one symbol carries g0 on I and g1 on Q.
- R9: With FEC on, six zero bits are encoded after the last input bit of each frame. The encoder starts every frame from an all-zero history.
- R10: With `cfg_unspread_i`=1, each symbol emits exactly one chip, equal to the symbol bit with no PN applied.
- R11: A configuration write made while a frame is in flight does not affect that frame. It applies to the next frame.
- R12: `data_ready_o` is 0 on every strobe that is not the final chip of its symbol. No strobe appears in the cycle after an accepted input bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write the cfg_* values into the shadow configuration |
| cfg_div_i | input | 8 | Chip divider: one chip every cfg_div_i+1 clocks |
| cfg_sf_i | input | 2 | Spreading factor code, 16 << code chips |
| cfg_unspread_i | input | 1 | One chip per symbol, PN bypassed |
| cfg_fec_i | input | 1 | Enable rate-1/2 convolutional encoder |
| cfg_qpsk_i | input | 1 | 1 = QPSK, 0 = BPSK |
| data_i | input | 1 | Serial user bit |
| data_valid_i | input | 1 | data_i is valid |
| data_last_i | input | 1 | data_i is the final bit of the frame |
| data_ready_o | output | 1 | Block accepts data_i this cycle |
| chip_i_o | output | 2 | In-phase chip, two's complement +1/-1 |
| chip_q_o | output | 2 | Quadrature chip, two's complement +1/-1 |
| chip_stb_o | output | 1 | Chip outputs are new this cycle |

## Verification
A bit accepted on one edge is loaded as a symbol on that same edge. Its first chip is emitted on the next divider tick, within `cfg_div_i`+1 edges. The chip appears at the outputs with the strobe one cycle after that tick. The bench does not predict absolute cycles, because the divider runs free. Instead it records each strobe with its cycle stamp at the falling edge and compares the chip stream in order with a model of the requirements. It then checks that successive stamps differ by exactly the tick period. Configuration changes are checked at frame granularity: a write takes two edges to reach the active copy, and the bench leaves several idle cycles after a frame's last strobe before offering the next frame.

// File: rtl/dsss_pkg.sv
package dsss_pkg;
  localparam int DIV_W      = 8;
  localparam int SF_CODE_W  = 2;
  localparam int MIN_SF_LOG = 4;
  localparam int CNT_W      = MIN_SF_LOG + (1 << SF_CODE_W) - 1;
  localparam int ENC_K      = 7;
  localparam int TAIL_LEN   = ENC_K - 1;
  localparam int TAIL_W     = $clog2(TAIL_LEN + 1);
  localparam int PN_W       = 7;

  localparam logic [DIV_W-1:0] DEF_DIV = DIV_W'(2);
  localparam logic [1:0]       LVL_POS = 2'b01;
  localparam logic [1:0]       LVL_NEG = 2'b11;

  typedef struct packed {
    logic [DIV_W-1:0]     div;
    logic [SF_CODE_W-1:0] sf_code;
    logic                 unspread;
    logic                 fec;
    logic                 qpsk;
  } cfg_t;
endpackage

// File: rtl/tick_div.sv
module tick_div #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  // >= so a shrinking divisor never waits for a wrap
  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
  parameter int         W    = 7,
  parameter logic [W-1:0] SEED = '1,
  parameter logic [W-1:0] TAPS = 7'b1100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic reseed_i,
  output logic pn_o
);
  logic [W-1:0] s_q;
  logic         fb;

  assign fb   = ^(s_q & TAPS);
  assign pn_o = s_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       s_q <= SEED;
    else if (reseed_i) s_q <= SEED;
    else if (step_i)   s_q <= {s_q[W-2:0], fb};
  end
endmodule

// File: rtl/conv_enc.sv
module conv_enc #(
  parameter int           K  = 7,
  parameter logic [K-1:0] G0 = 7'o171,
  parameter logic [K-1:0] G1 = 7'o133
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic       bit_i,
  output logic [1:0] code_o
);
  localparam logic [1:0][K-1:0] POLY = {G1, G0};

  logic [K-2:0] hist_q;
  logic [K-1:0] vec;

  // bit K-1 is the current input, bit 0 the oldest
  assign vec = {bit_i, hist_q};

  for (genvar g = 0; g < 2; g++) begin : g_out
    assign code_o[g] = ^(vec & POLY[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hist_q <= '0;
    else if (clr_i) hist_q <= '0;
    else if (en_i)  hist_q <= vec[K-1:1];
  end
endmodule

// File: rtl/dsss_tx.sv
module dsss_tx
  import dsss_pkg::*;
#(
  parameter logic [PN_W-1:0] PN_SEED = 7'h7F
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [DIV_W-1:0]     cfg_div_i,
  input  logic [SF_CODE_W-1:0] cfg_sf_i,
  input  logic                 cfg_unspread_i,
  input  logic                 cfg_fec_i,
  input  logic                 cfg_qpsk_i,
  input  logic                 data_i,
  input  logic                 data_valid_i,
  input  logic                 data_last_i,
  output logic                 data_ready_o,
  output logic [1:0]           chip_i_o,
  output logic [1:0]           chip_q_o,
  output logic                 chip_stb_o
);
  localparam cfg_t RST_CFG = '{div: DEF_DIV, sf_code: '0, unspread: 1'b0, fec: 1'b0, qpsk: 1'b0};

  cfg_t shadow_q, act_q;
  logic in_frame_q, last_seen_q;
  logic sym_valid_q, sym_i_q, sym_q_q;
  logic pend_valid_q, pend_bit_q;
  logic half_valid_q, half_bit_q;
  logic [TAIL_W-1:0] tail_left_q;
  logic [CNT_W-1:0]  chip_cnt_q, last_idx;
  logic [CNT_W:0]    sf_len;
  logic [1:0]        chip_i_q, chip_q_q;
  logic              stb_q;

  logic tick, pn_chip, pn_bit, emit, sym_end;
  logic accept, tail_step, frame_done;
  logic enc_en, enc_bit;
  logic [1:0] code;

  assign data_ready_o = !sym_valid_q && !pend_valid_q && !last_seen_q;
  assign accept       = data_valid_i && data_ready_o;
  assign tail_step    = in_frame_q && !sym_valid_q && !pend_valid_q && last_seen_q && (tail_left_q != '0);
  assign frame_done   = in_frame_q && !sym_valid_q && !pend_valid_q && last_seen_q && (tail_left_q == '0);

  assign sf_len   = (CNT_W+1)'(1) << (MIN_SF_LOG + int'(act_q.sf_code));
  assign last_idx = act_q.unspread ? '0 : CNT_W'(sf_len - (CNT_W+1)'(1));

  assign emit    = sym_valid_q && tick;
  assign sym_end = emit && (chip_cnt_q == last_idx);
  assign pn_bit  = act_q.unspread ? 1'b0 : pn_chip;

  assign enc_en  = act_q.fec && (accept || tail_step);
  assign enc_bit = tail_step ? 1'b0 : data_i;

  tick_div #(.W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (act_q.div),
    .tick_o(tick)
  );

  pn_lfsr #(.W(PN_W), .SEED(PN_SEED), .TAPS(7'b1100000)) u_pn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (emit && !sym_end),
    .reseed_i(sym_end),
    .pn_o    (pn_chip)
  );

  conv_enc #(.K(ENC_K), .G0(7'o171), .G1(7'o133)) u_enc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (enc_en),
    .clr_i (frame_done),
    .bit_i (enc_bit),
    .code_o(code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q     <= RST_CFG;
      act_q        <= RST_CFG;
      in_frame_q   <= 1'b0;
      last_seen_q  <= 1'b0;
      sym_valid_q  <= 1'b0;
      sym_i_q      <= 1'b0;
      sym_q_q      <= 1'b0;
      pend_valid_q <= 1'b0;
      pend_bit_q   <= 1'b0;
      half_valid_q <= 1'b0;
      half_bit_q   <= 1'b0;
      tail_left_q  <= '0;
      chip_cnt_q   <= '0;
      chip_i_q     <= LVL_POS;
      chip_q_q     <= LVL_POS;
      stb_q        <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (cfg_we_i)
        shadow_q <= '{div: cfg_div_i, sf_code: cfg_sf_i, unspread: cfg_unspread_i,
                      fec: cfg_fec_i, qpsk: cfg_qpsk_i};
      if (!in_frame_q && !accept) act_q <= shadow_q;

      if (accept) begin
        in_frame_q <= 1'b1;
        if (data_last_i) begin
          last_seen_q <= 1'b1;
          tail_left_q <= act_q.fec ? TAIL_W'(TAIL_LEN) : '0;
        end
      end
      if (frame_done) begin
        in_frame_q  <= 1'b0;
        last_seen_q <= 1'b0;
      end

      if (!sym_valid_q) begin
        if (pend_valid_q) begin
          sym_i_q      <= pend_bit_q;
          sym_q_q      <= pend_bit_q;
          sym_valid_q  <= 1'b1;
          pend_valid_q <= 1'b0;
        end else if (accept || tail_step) begin
          if (act_q.fec) begin
            sym_i_q     <= code[0];
            sym_q_q     <= act_q.qpsk ? code[1] : code[0];
            sym_valid_q <= 1'b1;
            if (!act_q.qpsk) begin
              pend_bit_q   <= code[1];
              pend_valid_q <= 1'b1;
            end
            if (tail_step) tail_left_q <= tail_left_q - TAIL_W'(1);
          end else if (act_q.qpsk) begin
            if (half_valid_q) begin
              sym_i_q      <= half_bit_q;
              sym_q_q      <= data_i;
              sym_valid_q  <= 1'b1;
              half_valid_q <= 1'b0;
            end else if (data_last_i) begin
              sym_i_q     <= data_i;
              sym_q_q     <= 1'b0;
              sym_valid_q <= 1'b1;
            end else begin
              half_bit_q   <= data_i;
              half_valid_q <= 1'b1;
            end
          end else begin
            sym_i_q     <= data_i;
            sym_q_q     <= data_i;
            sym_valid_q <= 1'b1;
          end
        end
      end else if (emit) begin
        stb_q    <= 1'b1;
        chip_i_q <= (sym_i_q ^ pn_bit) ? LVL_NEG : LVL_POS;
        chip_q_q <= (sym_q_q ^ pn_bit) ? LVL_NEG : LVL_POS;
        if (sym_end) begin
          sym_valid_q <= 1'b0;
          chip_cnt_q  <= '0;
        end else begin
          chip_cnt_q <= chip_cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign chip_i_o   = chip_i_q;
  assign chip_q_o   = chip_q_q;
  assign chip_stb_o = stb_q;
endmodule

// File: rtl/dsss_tx_chk.sv
module dsss_tx_chk
  import dsss_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             data_valid_i,
  input logic             data_ready_o,
  input logic             chip_stb_o,
  input logic [1:0]       chip_i_o,
  input logic [1:0]       chip_q_o,
  input logic             in_frame,
  input cfg_t             act_cfg,
  input logic             tick,
  input logic             sym_valid,
  input logic [CNT_W-1:0] chip_cnt,
  input logic [CNT_W-1:0] last_idx
);
  // R12
  accept_no_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_i && data_ready_o) |=> !chip_stb_o);

  // R11
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame && $past(in_frame)) |-> $stable(act_cfg));

  // R2
  stb_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_stb_o |-> $past(tick));

  // R5
  chip_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_stb_o |-> ((chip_i_o == LVL_POS || chip_i_o == LVL_NEG) &&
                    (chip_q_o == LVL_POS || chip_q_o == LVL_NEG)));

  // R6
  bpsk_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_stb_o && !act_cfg.qpsk) |-> (chip_i_o == chip_q_o));

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid |-> (chip_cnt <= last_idx));
endmodule

bind dsss_tx dsss_tx_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .data_valid_i(data_valid_i),
  .data_ready_o(data_ready_o),
  .chip_stb_o  (chip_stb_o),
  .chip_i_o    (chip_i_o),
  .chip_q_o    (chip_q_o),
  .in_frame    (in_frame_q),
  .act_cfg     (act_q),
  .tick        (tick),
  .sym_valid   (sym_valid_q),
  .chip_cnt    (chip_cnt_q),
  .last_idx    (last_idx)
);

// File: tb/dsss_tx_tb_top.sv
`timescale 1ns/1ps
module dsss_tx_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_div_i = 8'd2;
  logic [1:0] cfg_sf_i = 2'd0;
  logic       cfg_unspread_i = 1'b0, cfg_fec_i = 1'b0, cfg_qpsk_i = 1'b0;
  logic       data_i = 1'b0, data_valid_i = 1'b0, data_last_i = 1'b0;
  logic       data_ready_o, chip_stb_o;
  logic [1:0] chip_i_o, chip_q_o;

  int n_chk = 0, n_fail = 0, cyc = 0, rdy_viol = 0, cur_sf = 16;
  logic [1:0] exp_q[$];
  logic [1:0] act_q[$];
  int         stamp_q[$];

  // model configuration of the frame about to run
  int m_div = 2, m_sf = 0;
  bit m_uns = 0, m_fec = 0, m_qpsk = 0;

  always #10 clk_i = ~clk_i;

  dsss_tx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_div_i(cfg_div_i),
    .cfg_sf_i(cfg_sf_i), .cfg_unspread_i(cfg_unspread_i), .cfg_fec_i(cfg_fec_i),
    .cfg_qpsk_i(cfg_qpsk_i), .data_i(data_i), .data_valid_i(data_valid_i),
    .data_last_i(data_last_i), .data_ready_o(data_ready_o), .chip_i_o(chip_i_o),
    .chip_q_o(chip_q_o), .chip_stb_o(chip_stb_o)
  );

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (rst_ni && chip_stb_o) begin
      // R12: ready must be low unless this was a symbol's final chip
      if ((act_q.size() % cur_sf) != cur_sf - 1 && data_ready_o) rdy_viol++;
      act_q.push_back({chip_i_o == 2'b11, chip_q_o == 2'b11});
      stamp_q.push_back(cyc);
    end
  end

  task automatic check(bit ok, string req, string what, int a, int e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, a, e);
    end
  endtask

  task automatic drive_cfg(int div, int sf, bit uns, bit fec, bit qpsk);
    cfg_div_i = 8'(div); cfg_sf_i = 2'(sf); cfg_unspread_i = uns;
    cfg_fec_i = fec; cfg_qpsk_i = qpsk; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic set_cfg(int div, int sf, bit uns, bit fec, bit qpsk);
    drive_cfg(div, sf, uns, fec, qpsk);
    m_div = div; m_sf = sf; m_uns = uns; m_fec = fec; m_qpsk = qpsk;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic push_sym(bit bi, bit bq, int len);
    logic [6:0] s = 7'h7F;
    for (int k = 0; k < len; k++) begin
      bit pn = m_uns ? 1'b0 : s[6];
      exp_q.push_back({bi ^ pn, bq ^ pn});
      s = {s[5:0], s[6] ^ s[5]};
    end
  endtask

  task automatic build_exp(int nb, logic [15:0] bits);
    int len = m_uns ? 1 : (16 << m_sf);
    logic [5:0] hist = '0;
    exp_q.delete();
    if (m_fec) begin
      for (int k = 0; k < nb + 6; k++) begin
        logic [6:0] v = {(k < nb) ? bits[k] : 1'b0, hist};
        bit g0 = ^(v & 7'o171);
        bit g1 = ^(v & 7'o133);
        hist = v[6:1];
        if (m_qpsk) push_sym(g0, g1, len);
        else begin push_sym(g0, g0, len); push_sym(g1, g1, len); end
      end
    end else if (m_qpsk) begin
      for (int k = 0; k < nb; k += 2)
        push_sym(bits[k], (k + 1 < nb) ? bits[k+1] : 1'b0, len);
    end else begin
      for (int k = 0; k < nb; k++) push_sym(bits[k], bits[k], len);
    end
  endtask

  task automatic push_bit(bit b, bit last);
    data_i = b; data_last_i = last; data_valid_i = 1'b1;
    while (!data_ready_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic run_frame(string req, int nb, logic [15:0] bits, bit mid,
                           int nd, int ns, bit nu, bit nf, bit nq);
    int t = 0, bad = -1, bad_sp = -1;
    int limit;
    build_exp(nb, bits);
    act_q.delete(); stamp_q.delete(); rdy_viol = 0;
    cur_sf = m_uns ? 1 : (16 << m_sf);
    limit = exp_q.size() * (m_div + 2) + 400;
    fork
      begin
        for (int k = 0; k < nb; k++) push_bit(bits[k], k == nb - 1);
        data_valid_i = 1'b0; data_last_i = 1'b0;
      end
      begin
        if (mid) begin repeat (40) @(negedge clk_i); drive_cfg(nd, ns, nu, nf, nq); end
      end
    join
    while (act_q.size() < exp_q.size() && t < limit) begin @(negedge clk_i); t++; end
    repeat (4 * (m_div + 1) + 10) @(negedge clk_i);
    check(act_q.size() == exp_q.size(), req, "chip count", act_q.size(), exp_q.size());
    for (int k = 0; k < act_q.size() && k < exp_q.size(); k++)
      if (bad < 0 && act_q[k] != exp_q[k]) bad = k;
    check(bad < 0, req, "chip value (I,Q) at first mismatch",
          (bad < 0) ? 0 : int'(act_q[bad]), (bad < 0) ? 0 : int'(exp_q[bad]));
    for (int k = 1; k < stamp_q.size(); k++)
      if (bad_sp < 0 && stamp_q[k] - stamp_q[k-1] != m_div + 1) bad_sp = k;
    check(bad_sp < 0, "R2", "strobe spacing",
          (bad_sp < 0) ? m_div + 1 : stamp_q[bad_sp] - stamp_q[bad_sp-1], m_div + 1);
    check(rdy_viol == 0, "R12", "ready high mid-symbol", rdy_viol, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    check(data_ready_o == 1'b1, "R1", "ready after reset", data_ready_o, 1);
    check(chip_stb_o == 1'b0, "R1", "strobe after reset", chip_stb_o, 0);

    // R3 R4 R5 R6: BPSK uncoded, shortest code
    set_cfg(2, 0, 0, 0, 0);
    run_frame("R3 R4 R5 R6", 3, 16'b101, 0, 0, 0, 0, 0, 0);
    // R7: QPSK uncoded, odd length
    set_cfg(3, 0, 0, 0, 1);
    run_frame("R7", 5, 16'b10110, 0, 0, 0, 0, 0, 0);
    // R8 R9: FEC BPSK
    set_cfg(2, 0, 0, 1, 0);
    run_frame("R8 R9", 4, 16'b1101, 0, 0, 0, 0, 0, 0);
    // R8 R9: FEC QPSK, encoder history starts clean
    set_cfg(2, 1, 0, 1, 1);
    run_frame("R8 R9", 3, 16'b111, 0, 0, 0, 0, 0, 0);
    // R10: unspread
    set_cfg(2, 0, 1, 0, 0);
    run_frame("R10", 8, 16'b10011101, 0, 0, 0, 0, 0, 0);
    set_cfg(2, 2, 1, 0, 1);
    run_frame("R10 R7", 7, 16'b1100101, 0, 0, 0, 0, 0, 0);
    // R3: longest code, PN wraps past its period
    set_cfg(2, 3, 0, 0, 0);
    run_frame("R3 R4", 2, 16'b10, 0, 0, 0, 0, 0, 0);
    // R11: write during a frame is held until it ends
    set_cfg(2, 0, 0, 0, 0);
    run_frame("R11", 4, 16'b0110, 1, 3, 1, 0, 1, 1);
    m_div = 3; m_sf = 1; m_uns = 0; m_fec = 1; m_qpsk = 1;
    repeat (3) @(negedge clk_i);
    run_frame("R11 R8", 2, 16'b01, 0, 0, 0, 0, 0, 0);

    // random configurations and payloads
    for (int r = 0; r < 6; r++) begin
      int div = 2 + int'($urandom % 2);
      int sf = int'($urandom % 4);
      bit uns = ($urandom % 5) == 0;
      bit fec = $urandom % 2;
      bit qpsk = $urandom % 2;
      int nb = 1 + int'($urandom % 6);
      logic [15:0] bits = 16'($urandom);
      set_cfg(div, sf, uns, fec, qpsk);
      run_frame("R3 R4 R7 R8 R9 R10", nb, bits, 0, 0, 0, 0, 0, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule